// File: doc/BRIEF.md
# Polled Service Arbiter with Time Slice

This block chooses which of several devices the processor serves next. Every device raises a ready bit. The arbiter merges all ready bits into one shared request output, so a handler never needs to know in advance which device is asking. When any ready bit is set, the arbiter walks through the devices one per clock. It starts at a rotating pointer and grants the first ready device it meets.

A grant drives the device index and an active flag. It also starts a slice counter, which loads its length from a programmable input at the moment of the grant. The grant ends in one of two ways. The handler can pulse `done`, which ends the grant as a normal completion. Otherwise the slice runs out, which ends the grant as a timeout. Each outcome has its own one-cycle flag.

In both cases the pointer moves to the device just after the one served. A device that was cut off by a timeout keeps its ready bit, but it is considered again only when the scan wraps back around to it. If a full pass finds no ready device, the arbiter goes back to waiting on the shared request and leaves the pointer where it was.

Top module: `poll_service_arbiter`

## Requirements
- R1: `any_req` equals the OR of all `ready` bits as they stood at the previous rising clock edge (one register stage).
- R2: From idle, the first edge at which any `ready` bit is set moves the arbiter into scanning. Scanning then checks one device per clock edge, starting at the pointer and going up in index with wrap-around. If the first ready device is `d` positions past the pointer, `svc_active` is high after edge `2+d` counted from that first edge.
- R3: The granted device is the first device, in circular order starting at the pointer, whose ready bit is set. `svc_idx` carries its index in plain binary.
- R4: `svc_active` stays high from the grant until the grant ends, and `svc_idx` holds its value throughout.
- R5: `slice_len` is captured only at the grant edge, and a value of 0 is treated as 1. Without `done`, `svc_active` stays high for exactly that many cycles. On the edge that ends the grant, `slice_timeout` pulses for one cycle and `svc_active` falls.
- R6: A `done` seen at an edge while `svc_active` is high ends the grant at that edge. `svc_done` then pulses for one cycle. If `done` arrives on the same edge that the slice expires, completion wins and `slice_timeout` stays low.
- R7: After either kind of ending, the pointer becomes the served index plus one, modulo the device count. A device that timed out and is still ready therefore waits until the scan reaches it again.
- R8: A scan pass that checks every device without finding one ready returns the arbiter to idle without a grant, and the pointer ends where the pass began.
- R9: A `done` pulse while no grant is active has no effect: no `svc_done` pulse, no grant, and no pointer movement.
- R10: Synchronous reset clears `svc_active`, `svc_idx`, `svc_done`, `slice_timeout` and `any_req`, and sets the pointer to device 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | input | N_DEV | Per-device ready bits |
| done | input | 1 | Handler completion pulse |
| slice_len | input | SLICE_W | Slice length in cycles, captured at grant (0 acts as 1) |
| svc_idx | output | $clog2(N_DEV) | Index of the granted device |
| svc_active | output | 1 | A grant is in progress |
| any_req | output | 1 | Shared request: OR of ready bits, registered |
| svc_done | output | 1 | One-cycle flag: grant ended by completion |
| slice_timeout | output | 1 | One-cycle flag: grant ended by slice expiry |

## Verification
The assertions assume that `done` is only meaningful while a grant is active. They also assume that `ready` and `slice_len` are stable across each clock edge. The bench satisfies this by changing every input only at the falling edge. The slice-bound assertion relies on `slice_len` as it stood just before the grant edge. For that reason, the bench changes `slice_len` only after it sees the grant, which also tests that the length is captured at the grant. The sweep covers every nonzero ready pattern of a four-device setup with a slice length of zero or more. It ends every grant by timeout, by an early `done`, or by a `done` on the final slice cycle.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_SERVE = 2'd2
  } arb_state_t;

endpackage

// File: rtl/poll_scan_ptr.sv
module poll_scan_ptr #(
  parameter int N_DEV = 8,
  parameter int IDX_W = $clog2(N_DEV)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DEV-1:0] ready_i,
  input  logic             advance_i,
  input  logic             restart_i,
  input  logic [IDX_W-1:0] restart_idx_i,
  input  logic             pass_clr_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             hit_o,
  output logic             pass_last_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DEV - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] pass_q;
  logic [IDX_W-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      pass_q <= '0;
    end else begin
      if (restart_i)
        ptr_q <= restart_idx_i;
      else if (advance_i)
        ptr_q <= ptr_nxt;

      if (pass_clr_i)
        pass_q <= '0;
      else if (advance_i)
        pass_q <= pass_q + 1'b1;
    end
  end

  assign ptr_o       = ptr_q;
  assign hit_o       = ready_i[ptr_q];
  assign pass_last_o = (pass_q == LAST_IDX);

endmodule

// File: rtl/poll_slice_timer.sv
module poll_slice_timer #(
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [SLICE_W-1:0] len_i,
  input  logic               run_i,
  output logic               expire_o
);

  localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

  logic [SLICE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ONE;
    end else if (start_i) begin
      cnt_q <= (len_i == '0) ? ONE : len_i;
    end else if (run_i && cnt_q != ONE) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_i && (cnt_q == ONE);

endmodule

// File: rtl/poll_arb_ctrl.sv
module poll_arb_ctrl
  import poll_arb_pkg::*;
#(
  parameter int N_DEV = 8,
  parameter int IDX_W = $clog2(N_DEV)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_any_i,
  input  logic             done_i,
  input  logic             hit_i,
  input  logic             pass_last_i,
  input  logic [IDX_W-1:0] ptr_i,
  input  logic             expire_i,
  output logic             advance_o,
  output logic             restart_o,
  output logic [IDX_W-1:0] restart_idx_o,
  output logic             pass_clr_o,
  output logic             timer_start_o,
  output logic             timer_run_o,
  output logic [IDX_W-1:0] sel_o,
  output logic             active_o,
  output logic             cmpl_o,
  output logic             tmo_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DEV - 1);

  arb_state_t       st_q, st_d;
  logic [IDX_W-1:0] sel_q;
  logic             active_q, cmpl_q, tmo_q;
  logic             end_ok, end_tmo;

  always_comb begin
    st_d          = st_q;
    advance_o     = 1'b0;
    pass_clr_o    = 1'b0;
    timer_start_o = 1'b0;
    end_ok        = 1'b0;
    end_tmo       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        pass_clr_o = 1'b1;
        if (req_any_i) st_d = ST_SCAN;
      end
      ST_SCAN: begin
        if (hit_i) begin
          timer_start_o = 1'b1;
          st_d          = ST_SERVE;
        end else begin
          advance_o = 1'b1;
          if (pass_last_i) st_d = ST_IDLE;
        end
      end
      ST_SERVE: begin
        if (done_i) begin
          end_ok = 1'b1;
          st_d   = ST_IDLE;
        end else if (expire_i) begin
          end_tmo = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign timer_run_o   = (st_q == ST_SERVE);
  assign restart_o     = end_ok || end_tmo;
  assign restart_idx_o = (sel_q == LAST_IDX) ? '0 : sel_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      sel_q    <= '0;
      active_q <= 1'b0;
      cmpl_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmpl_q <= end_ok;
      tmo_q  <= end_tmo;
      if (timer_start_o) begin
        sel_q    <= ptr_i;
        active_q <= 1'b1;
      end else if (restart_o) begin
        active_q <= 1'b0;
      end
    end
  end

  assign sel_o    = sel_q;
  assign active_o = active_q;
  assign cmpl_o   = cmpl_q;
  assign tmo_o    = tmo_q;

endmodule

// File: rtl/poll_service_arbiter.sv
module poll_service_arbiter #(
  parameter int N_DEV   = 8,
  parameter int SLICE_W = 8,
  localparam int IDX_W  = $clog2(N_DEV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_DEV-1:0]   ready,
  input  logic               done,
  input  logic [SLICE_W-1:0] slice_len,
  output logic [IDX_W-1:0]   svc_idx,
  output logic               svc_active,
  output logic               any_req,
  output logic               svc_done,
  output logic               slice_timeout
);

  logic             req_comb;
  logic             advance, restart, pass_clr, pass_last, hit;
  logic             tmr_start, tmr_run, expire;
  logic [IDX_W-1:0] ptr, restart_idx;
  logic             any_req_q;

  assign req_comb = |ready;

  always_ff @(posedge clk) begin
    if (rst) any_req_q <= 1'b0;
    else     any_req_q <= req_comb;
  end
  assign any_req = any_req_q;

  poll_scan_ptr #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_scan (
    .clk          (clk),
    .rst          (rst),
    .ready_i      (ready),
    .advance_i    (advance),
    .restart_i    (restart),
    .restart_idx_i(restart_idx),
    .pass_clr_i   (pass_clr),
    .ptr_o        (ptr),
    .hit_o        (hit),
    .pass_last_o  (pass_last)
  );

  poll_slice_timer #(.SLICE_W(SLICE_W)) u_slice (
    .clk     (clk),
    .rst     (rst),
    .start_i (tmr_start),
    .len_i   (slice_len),
    .run_i   (tmr_run),
    .expire_o(expire)
  );

  poll_arb_ctrl #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_any_i    (req_comb),
    .done_i       (done),
    .hit_i        (hit),
    .pass_last_i  (pass_last),
    .ptr_i        (ptr),
    .expire_i     (expire),
    .advance_o    (advance),
    .restart_o    (restart),
    .restart_idx_o(restart_idx),
    .pass_clr_o   (pass_clr),
    .timer_start_o(tmr_start),
    .timer_run_o  (tmr_run),
    .sel_o        (svc_idx),
    .active_o     (svc_active),
    .cmpl_o       (svc_done),
    .tmo_o        (slice_timeout)
  );

endmodule

// File: rtl/poll_service_arbiter_chk.sv
module poll_service_arbiter_chk #(
  parameter int N_DEV   = 8,
  parameter int SLICE_W = 8,
  localparam int IDX_W  = $clog2(N_DEV)
) (
  input logic               clk,
  input logic               rst,
  input logic [N_DEV-1:0]   ready,
  input logic               done,
  input logic [SLICE_W-1:0] slice_len,
  input logic [IDX_W-1:0]   svc_idx,
  input logic               svc_active,
  input logic               any_req,
  input logic               svc_done,
  input logic               slice_timeout
);

  logic [N_DEV-1:0]   ready_q;
  logic [SLICE_W-1:0] len_q;
  logic               act_q;
  logic [SLICE_W:0]   run_q;
  logic [SLICE_W:0]   lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= '0;
      len_q   <= '0;
      act_q   <= 1'b0;
      run_q   <= '0;
      lim_q   <= '0;
    end else begin
      ready_q <= ready;
      len_q   <= slice_len;
      act_q   <= svc_active;
      if (svc_active && !act_q) begin
        lim_q <= (len_q == '0) ? (SLICE_W+1)'(1) : {1'b0, len_q};
        run_q <= (SLICE_W+1)'(1);
      end else if (svc_active) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assert_req_high_R1: assert property (@(posedge clk) disable iff (rst)
    (|ready) |=> any_req);

  assert_req_low_R1: assert property (@(posedge clk) disable iff (rst)
    !(|ready) |=> !any_req);

  assert_grant_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (svc_active && !act_q) |-> ready_q[svc_idx]);

  assert_sel_hold_R4: assert property (@(posedge clk) disable iff (rst)
    svc_active |=> (!svc_active || $stable(svc_idx)));

  assert_slice_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (svc_active && act_q) |-> (run_q < lim_q));

  assert_timeout_drop_R5: assert property (@(posedge clk) disable iff (rst)
    slice_timeout |-> (!svc_active && act_q));

  assert_done_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (svc_active && done) |=> (!svc_active && svc_done && !slice_timeout));

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (rst)
    !(svc_done && slice_timeout));

  assert_idle_done_R9: assert property (@(posedge clk) disable iff (rst)
    (!svc_active && done) |=> (!svc_done && !svc_active));

endmodule

bind poll_service_arbiter poll_service_arbiter_chk #(
  .N_DEV  (N_DEV),
  .SLICE_W(SLICE_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ready        (ready),
  .done         (done),
  .slice_len    (slice_len),
  .svc_idx      (svc_idx),
  .svc_active   (svc_active),
  .any_req      (any_req),
  .svc_done     (svc_done),
  .slice_timeout(slice_timeout)
);

// File: tb/poll_service_arbiter_test.sv
module poll_service_arbiter_test;

  localparam int N   = 4;
  localparam int SW  = 4;
  localparam int IW  = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  ready = '0;
  logic          done = 1'b0;
  logic [SW-1:0] slice_len = '0;
  logic [IW-1:0] svc_idx;
  logic          svc_active, any_req, svc_done, slice_timeout;

  int n_chk  = 0;
  int n_fail = 0;
  int mp     = 0;

  always #10 clk = ~clk;

  poll_service_arbiter #(.N_DEV(N), .SLICE_W(SW)) uut (
    .clk(clk), .rst(rst), .ready(ready), .done(done), .slice_len(slice_len),
    .svc_idx(svc_idx), .svc_active(svc_active), .any_req(any_req),
    .svc_done(svc_done), .slice_timeout(slice_timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: early done, 1: done on last slice cycle, 2: timeout with slice_len changed after grant
  task automatic run_trial(input logic [N-1:0] pat, input int lenval, input int mode);
    int d = -1;
    int exp_sel = 0;
    int lim;
    int cyc = 0;
    int n;
    for (int k = 0; k < N; k++)
      if (d < 0 && pat[(mp + k) % N]) begin
        d = k;
        exp_sel = (mp + k) % N;
      end
    lim = (lenval == 0) ? 1 : lenval;
    @(negedge clk);
    ready = pat;
    slice_len = SW'(lenval);
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) check(any_req == 1'b1, "R1 any_req high", int'(any_req), 1);
    end while (!svc_active && cyc < 60);
    check(cyc == 2 + d, "R2 grant latency", cyc, 2 + d);
    check(int'(svc_idx) == exp_sel, "R3/R7 granted index", int'(svc_idx), exp_sel);
    if (mode == 2) begin
      slice_len = SW'((lenval + 3) % 16);
      n = 1;
      forever begin
        @(negedge clk);
        if (!svc_active) break;
        n++;
        if (int'(svc_idx) != exp_sel) check(1'b0, "R4 index held", int'(svc_idx), exp_sel);
        if (n > 40) break;
      end
      check(n == lim, "R5 slice duration", n, lim);
      check(slice_timeout == 1'b1, "R5 timeout flag", int'(slice_timeout), 1);
      check(svc_done == 1'b0, "R5 no completion on timeout", int'(svc_done), 0);
    end else begin
      int j = (mode == 1) ? lim - 1 : 0;
      repeat (j) begin
        @(negedge clk);
        check(svc_active == 1'b1, "R4 active held", int'(svc_active), 1);
      end
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      check(svc_active == 1'b0, "R6 active drops on done", int'(svc_active), 0);
      check(svc_done == 1'b1, "R6 completion flag", int'(svc_done), 1);
      check(slice_timeout == 1'b0, "R6 done wins over timeout", int'(slice_timeout), 0);
    end
    ready = '0;
    mp = (exp_sel + 1) % N;
    @(negedge clk);
    @(negedge clk);
    check(any_req == 1'b0, "R1 any_req low", int'(any_req), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(svc_active == 1'b0, "R10 reset active", int'(svc_active), 0);
    check(svc_idx == '0, "R10 reset index", int'(svc_idx), 0);
    check(any_req == 1'b0, "R10 reset any_req", int'(any_req), 0);
    check(svc_done == 1'b0 && slice_timeout == 1'b0, "R10 reset flags",
          int'({svc_done, slice_timeout}), 0);
    rst = 1'b0;

    // R9: done with no grant must change nothing
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    check(svc_done == 1'b0, "R9 idle done ignored", int'(svc_done), 0);
    check(svc_active == 1'b0, "R9 idle done no grant", int'(svc_active), 0);
    run_trial(4'b1111, 2, 0);   // pointer still 0 -> device 0

    for (int pat = 1; pat < 16; pat++) begin
      for (int rep = 0; rep < 4; rep++) begin
        run_trial(N'(pat), (pat + rep) % 5, (pat + rep) % 3);
      end
    end

    // R8: one-cycle request, nothing ready during the pass
    for (int t = 0; t < 2; t++) begin
      int saw = 0;
      @(negedge clk);
      ready = N'(4'b1001);
      @(negedge clk);
      ready = '0;
      repeat (N + 3) begin
        @(negedge clk);
        if (svc_active) saw = 1;
      end
      check(saw == 0, "R8 empty pass no grant", saw, 0);
      run_trial(N'(4'b0110), 3, t);  // latency proves pointer unchanged
    end

    // R7: timed-out device still ready waits a full wrap
    run_trial(4'b0100, 1, 2);
    run_trial(4'b0100, 2, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule